// File: doc/BRIEF.md
# System Mode Controller

This block is the supervisory state machine of a supply and bus companion device. It tracks one of five operating modes (Off, Standby, Normal, Sleep and Overtemp) and decides, on every clock, whether the voltage regulator that feeds the host processor stays enabled and whether the host is held in reset. It takes its inputs from the battery comparators, the over-temperature sensor, a mode request from the register bank, the interrupt and wake-up logic, and an external reset line. It drives the current mode, the regulator enable, an active-low system reset of programmable width and a one-cycle strobe that clears pending wake events.

Battery supply flags take precedence over everything else: a low battery shuts the regulator off at once, whatever mode is active. A request to sleep is checked against the interrupt state, the wake-up state and the wake-source enables. When the request cannot be granted, the controller stays where it is and pulses a short reset, so the host restarts from a known point. It does not drift into a state it cannot leave.

Top module: `sysmode_ctrl`

## Requirements
- R1: While `bat_off` is 1, the next mode is Off (code 0) from any mode, and in Off both `reg_en` and `rst_out_n` are 0. This input takes priority over every other input.
- R2: In Off with `bat_off` 0 and `bat_on` 1, the next mode is Standby (code 1). A system reset starts: `rst_out_n` is 0 for 20 cycles when `long_rst_sel` is 1, and for 4 cycles when it is 0.
- R3: Outside Off, with `overtemp` 1, the next mode is Overtemp (code 4), where `reg_en` and `rst_out_n` are 0. When the flag clears, the controller goes to Standby and issues a reset of the selected width.
- R4: A request (`req_valid` 1) is acted on only in Standby or Normal. The `req_mode` values are 0 for Standby, 1 for Normal (code 2) and 2 for Sleep (code 3); value 3 is ignored. Requests made in Off, Sleep or Overtemp leave the mode unchanged.
- R5: A Sleep request enters Sleep only when `irq_pending` is 0, `wake_pend` is 0 and at least one bit of `wake_en` is 1.
- R6: A Sleep request that fails any condition of R5 leaves the mode unchanged and drives `rst_out_n` to 0 for exactly 4 cycles, whatever the value of `long_rst_sel`.
- R7: `wake_clr` is 1 for exactly one cycle, the first cycle in which the mode is Normal after any other mode.
- R8: `ext_rst_n` held at 0 for 3 consecutive cycles, while the mode is Standby, Normal or Sleep, gives one reset of the selected width and sets the mode to Standby. A low pulse of fewer than 3 cycles has no effect, and one low interval gives only one reset.
- R9: In Sleep, `wake_pend` at 1 returns the controller to Standby with a reset of the selected width.
- R10: A new reset trigger during a running reset restarts the count at the full new width. In Standby, Normal and Sleep `reg_en` is 1, and `rst_out_n` is 1 whenever no reset is counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bat_off | input | 1 | Battery below power-off threshold |
| bat_on | input | 1 | Battery above power-on threshold |
| overtemp | input | 1 | Junction over-temperature flag |
| req_valid | input | 1 | Mode request strobe from register bank |
| req_mode | input | 2 | Requested mode: 0 Standby, 1 Normal, 2 Sleep, 3 ignored |
| irq_pending | input | 1 | At least one interrupt pending |
| wake_en | input | WAKE_SRC | Enables of the wake sources |
| wake_pend | input | 1 | At least one wake event pending |
| ext_rst_n | input | 1 | External reset request, active low |
| long_rst_sel | input | 1 | 1 selects the long system reset width |
| mode | output | 3 | Current mode: 0 Off, 1 Standby, 2 Normal, 3 Sleep, 4 Overtemp |
| reg_en | output | 1 | Host regulator enable |
| rst_out_n | output | 1 | System reset output, active low |
| wake_clr | output | 1 | Clear pending wake events |

## Verification
The hardest situations to reach are those where two triggers coincide. Examples are a refused Sleep request arriving while a long reset is still counting, and an external reset qualifying in the same cycle as a request or a temperature change. Here priority and counter restart decide the outcome. The stimulus first walks the controller into Normal and Sleep in the normal way. It then issues back-to-back refused requests a few cycles apart, holds the external line low across mode changes, and raises the battery and temperature flags during active resets. A behavioural model of the mode and the reset counter is compared with every output on every clock.

// File: rtl/sysmode_pkg.sv
package sysmode_pkg;

  typedef enum logic [2:0] {
    MD_OFF   = 3'd0,
    MD_STBY  = 3'd1,
    MD_NORM  = 3'd2,
    MD_SLEEP = 3'd3,
    MD_HOT   = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    RQ_STBY  = 2'd0,
    RQ_NORM  = 2'd1,
    RQ_SLEEP = 2'd2,
    RQ_NONE  = 2'd3
  } req_e;

  function automatic logic powered(input mode_e m);
    return (m == MD_STBY) || (m == MD_NORM) || (m == MD_SLEEP);
  endfunction

endpackage

// File: rtl/sysmode_extrst.sv
module sysmode_extrst #(
  parameter int unsigned MIN_LOW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  output logic det
);
  localparam int unsigned CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LIM  = CW'(MIN_LOW);
  localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);

  logic [CW-1:0] low_q, low_d;
  logic          det_q, det_d;

  always_comb begin
    low_d = '0;
    det_d = 1'b0;
    if (!line_n) begin
      det_d = (low_q == LAST);
      low_d = (low_q < LIM) ? low_q + 1'b1 : low_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
      det_q <= 1'b0;
    end else begin
      low_q <= low_d;
      det_q <= det_d;
    end
  end

  assign det = det_q;
endmodule

// File: rtl/sysmode_rstgen.sv
module sysmode_rstgen #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          fire,
  input  logic [CW-1:0] width,
  output logic          busy
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clr || fire || (cnt_q != '0);

  always_comb begin
    if (clr)       cnt_d = '0;
    else if (fire) cnt_d = width;
    else           cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/sysmode_fsm.sv
module sysmode_fsm
  import sysmode_pkg::*;
#(
  parameter int unsigned WAKE_SRC    = 2,
  parameter int unsigned SHORT_TICKS = 4,
  parameter int unsigned LONG_TICKS  = 20,
  parameter int unsigned CW          = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bat_off,
  input  logic                bat_on,
  input  logic                overtemp,
  input  logic                req_valid,
  input  logic [1:0]          req_mode,
  input  logic                irq_pending,
  input  logic [WAKE_SRC-1:0] wake_en,
  input  logic                wake_pend,
  input  logic                ext_det,
  input  logic                long_sel,
  output mode_e               mode,
  output logic                fire,
  output logic [CW-1:0]       fire_w,
  output logic                hold_clr,
  output logic                wake_clr
);
  localparam logic [CW-1:0] SHORT_W = CW'(SHORT_TICKS);
  localparam logic [CW-1:0] LONG_W  = CW'(LONG_TICKS);

  mode_e         mode_q, mode_d;
  logic          wclr_q, wclr_d;
  logic [CW-1:0] sel_w;
  logic          sleep_ok;
  req_e          req;

  assign sel_w    = long_sel ? LONG_W : SHORT_W;
  assign sleep_ok = !irq_pending && !wake_pend && (|wake_en);
  assign req      = req_e'(req_mode);

  always_comb begin
    mode_d = mode_q;
    fire   = 1'b0;
    fire_w = sel_w;
    if (bat_off) begin
      mode_d = MD_OFF;
    end else if (mode_q == MD_OFF) begin
      if (bat_on) begin
        mode_d = MD_STBY;
        fire   = 1'b1;
      end
    end else if (overtemp) begin
      mode_d = MD_HOT;
    end else if (mode_q == MD_HOT) begin
      mode_d = MD_STBY;
      fire   = 1'b1;
    end else if (ext_det) begin
      mode_d = MD_STBY;
      fire   = 1'b1;
    end else if (mode_q == MD_SLEEP) begin
      if (wake_pend) begin
        mode_d = MD_STBY;
        fire   = 1'b1;
      end
    end else if (req_valid) begin
      case (req)
        RQ_STBY:  mode_d = MD_STBY;
        RQ_NORM:  mode_d = MD_NORM;
        RQ_SLEEP: begin
          if (sleep_ok) begin
            mode_d = MD_SLEEP;
          end else begin
            fire   = 1'b1;
            fire_w = SHORT_W;
          end
        end
        default:  mode_d = mode_q;
      endcase
    end
  end

  assign hold_clr = (mode_d == MD_OFF) || (mode_d == MD_HOT);
  assign wclr_d   = (mode_d == MD_NORM) && (mode_q != MD_NORM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_OFF;
      wclr_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      wclr_q <= wclr_d;
    end
  end

  assign mode     = mode_q;
  assign wake_clr = wclr_q;
endmodule

// File: rtl/sysmode_ctrl.sv
module sysmode_ctrl
  import sysmode_pkg::*;
#(
  parameter int unsigned WAKE_SRC    = 2,
  parameter int unsigned SHORT_TICKS = 4,
  parameter int unsigned LONG_TICKS  = 20,
  parameter int unsigned EXT_MIN     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bat_off,
  input  logic                bat_on,
  input  logic                overtemp,
  input  logic                req_valid,
  input  logic [1:0]          req_mode,
  input  logic                irq_pending,
  input  logic [WAKE_SRC-1:0] wake_en,
  input  logic                wake_pend,
  input  logic                ext_rst_n,
  input  logic                long_rst_sel,
  output logic [2:0]          mode,
  output logic                reg_en,
  output logic                rst_out_n,
  output logic                wake_clr
);
  localparam int unsigned MAXW = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int unsigned CW   = $clog2(MAXW + 1);

  mode_e         cur_mode;
  logic          ext_det;
  logic          fire;
  logic [CW-1:0] fire_w;
  logic          hold_clr;
  logic          busy;

  sysmode_extrst #(.MIN_LOW(EXT_MIN)) u_extrst (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_n (ext_rst_n),
    .det    (ext_det)
  );

  sysmode_fsm #(
    .WAKE_SRC    (WAKE_SRC),
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_TICKS  (LONG_TICKS),
    .CW          (CW)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .bat_off     (bat_off),
    .bat_on      (bat_on),
    .overtemp    (overtemp),
    .req_valid   (req_valid),
    .req_mode    (req_mode),
    .irq_pending (irq_pending),
    .wake_en     (wake_en),
    .wake_pend   (wake_pend),
    .ext_det     (ext_det),
    .long_sel    (long_rst_sel),
    .mode        (cur_mode),
    .fire        (fire),
    .fire_w      (fire_w),
    .hold_clr    (hold_clr),
    .wake_clr    (wake_clr)
  );

  sysmode_rstgen #(.CW(CW)) u_rstgen (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hold_clr),
    .fire  (fire),
    .width (fire_w),
    .busy  (busy)
  );

  assign mode      = cur_mode;
  assign reg_en    = powered(cur_mode);
  assign rst_out_n = reg_en && !busy;
endmodule

// File: rtl/sysmode_chk.sv
module sysmode_chk #(
  parameter int unsigned WAKE_SRC = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bat_off,
  input logic                bat_on,
  input logic                overtemp,
  input logic                req_valid,
  input logic [1:0]          req_mode,
  input logic                irq_pending,
  input logic [WAKE_SRC-1:0] wake_en,
  input logic                wake_pend,
  input logic                ext_det,
  input logic [2:0]          mode,
  input logic                reg_en,
  input logic                rst_out_n,
  input logic                wake_clr
);
  logic live;
  assign live = (mode == 3'd1) || (mode == 3'd2) || (mode == 3'd3);

  a_r1_off_forced: assert property (@(posedge clk) disable iff (!rst_n)
    bat_off |=> (mode == 3'd0) && !reg_en && !rst_out_n);

  a_r2_power_up: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) && !bat_off && bat_on |=> (mode == 3'd1) && !rst_out_n);

  a_r3_hot_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd0) && !bat_off && overtemp |=> (mode == 3'd4) && !reg_en);

  a_r5_sleep_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3) && ($past(mode) != 3'd3) |->
      $past(!irq_pending && !wake_pend && (wake_en != '0)));

  a_r6_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_mode == 2'd2) && ((mode == 3'd1) || (mode == 3'd2)) &&
    irq_pending && !bat_off && !overtemp && !ext_det
      |=> (mode == $past(mode)) && !rst_out_n);

  a_r7_wake_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wake_clr |-> (mode == 3'd2) && ($past(mode) != 3'd2));

  a_r8_ext_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ext_det && live && !bat_off && !overtemp |=> (mode == 3'd1) && !rst_out_n);

  a_r10_powered: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> reg_en);
endmodule

bind sysmode_ctrl sysmode_chk #(.WAKE_SRC(WAKE_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bat_off     (bat_off),
  .bat_on      (bat_on),
  .overtemp    (overtemp),
  .req_valid   (req_valid),
  .req_mode    (req_mode),
  .irq_pending (irq_pending),
  .wake_en     (wake_en),
  .wake_pend   (wake_pend),
  .ext_det     (ext_det),
  .mode        (mode),
  .reg_en      (reg_en),
  .rst_out_n   (rst_out_n),
  .wake_clr    (wake_clr)
);

// File: tb/test_sysmode_ctrl.sv
module test_sysmode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bat_off, bat_on, overtemp, req_valid;
  logic [1:0] req_mode;
  logic       irq_pending, wake_pend, ext_rst_n, long_rst_sel;
  logic [1:0] wake_en;
  logic [2:0] mode;
  logic       reg_en, rst_out_n, wake_clr;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  sysmode_ctrl i_sysmode_ctrl (
    .clk(clk), .rst_n(rst_n), .bat_off(bat_off), .bat_on(bat_on),
    .overtemp(overtemp), .req_valid(req_valid), .req_mode(req_mode),
    .irq_pending(irq_pending), .wake_en(wake_en), .wake_pend(wake_pend),
    .ext_rst_n(ext_rst_n), .long_rst_sel(long_rst_sel), .mode(mode),
    .reg_en(reg_en), .rst_out_n(rst_out_n), .wake_clr(wake_clr));

  // Behavioural reference: mode, reset countdown, low-run length, qualified flag
  int  m_mode, m_cnt, m_low;
  bit  m_det, m_wclr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_low = 0; m_det = 0; m_wclr = 0;
    end else begin
      int nm, w;
      bit f, ok;
      nm = m_mode; f = 0; w = long_rst_sel ? 20 : 4;
      ok = !irq_pending && !wake_pend && (wake_en != 0);
      if (bat_off) nm = 0;
      else if (m_mode == 0) begin if (bat_on) begin nm = 1; f = 1; end end
      else if (overtemp) nm = 4;
      else if (m_mode == 4) begin nm = 1; f = 1; end
      else if (m_det) begin nm = 1; f = 1; end
      else if (m_mode == 3) begin if (wake_pend) begin nm = 1; f = 1; end end
      else if (req_valid) begin
        if (req_mode == 0) nm = 1;
        else if (req_mode == 1) nm = 2;
        else if (req_mode == 2) begin
          if (ok) nm = 3; else begin f = 1; w = 4; end
        end
      end
      if (nm == 0 || nm == 4) m_cnt = 0;
      else if (f) m_cnt = w;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_wclr = (nm == 2) && (m_mode != 2);
      m_mode = nm;
      if (!ext_rst_n) begin m_det = (m_low == 2); if (m_low < 3) m_low++; end
      else begin m_low = 0; m_det = 0; end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", phase, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit pw;
    cyc++;
    pw = (m_mode >= 1 && m_mode <= 3);
    chk("mode", mode, m_mode);
    chk("reg_en", reg_en, pw);
    chk("rst_out_n", rst_out_n, pw && (m_cnt == 0));
    chk("wake_clr", wake_clr, m_wclr);
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic request(input logic [1:0] r);
    @(negedge clk); req_valid = 1'b1; req_mode = r;
    @(negedge clk); req_valid = 1'b0;
  endtask

  initial begin
    rst_n = 0; bat_off = 0; bat_on = 0; overtemp = 0; req_valid = 0;
    req_mode = 0; irq_pending = 0; wake_pend = 0; ext_rst_n = 1;
    long_rst_sel = 1; wake_en = 2'b00;
    #23 rst_n = 1;
    @(negedge clk);
    phase = "R1";
    chk("reset mode", mode, 0); chk("reset reg_en", reg_en, 0); chk("reset rst_out_n", rst_out_n, 0);
    phase = "R4"; request(2'd1); wait_n(3);           // ignored in Off
    phase = "R2"; bat_on = 1; wait_n(30);
    phase = "R7"; request(2'd1); wait_n(5);
    phase = "R4"; request(2'd3); wait_n(3);           // reserved code
    phase = "R5"; wake_en = 2'b01; request(2'd2); wait_n(4);
    phase = "R4"; request(2'd1); wait_n(3);           // ignored in Sleep
    phase = "R9"; @(negedge clk); wake_pend = 1; @(negedge clk); wake_pend = 0; wait_n(25);
    phase = "R6"; long_rst_sel = 0; request(2'd1); irq_pending = 1; request(2'd2); wait_n(8);
    irq_pending = 0; wake_en = 2'b00; request(2'd2); wait_n(8);
    wake_en = 2'b10; wake_pend = 1; request(2'd2); wake_pend = 0; wait_n(8);
    phase = "R10"; long_rst_sel = 1; irq_pending = 1; request(2'd2); wait_n(1);
    request(2'd2); irq_pending = 0; wait_n(8);
    request(2'd0); @(negedge clk); ext_rst_n = 0; wait_n(3); ext_rst_n = 1; wait_n(25);
    phase = "R8"; request(2'd1); @(negedge clk); ext_rst_n = 0; wait_n(2); ext_rst_n = 1; wait_n(4);
    ext_rst_n = 0; wait_n(8); ext_rst_n = 1; wait_n(25);
    phase = "R3"; request(2'd1); overtemp = 1; wait_n(5);
    request(2'd1); wait_n(2); overtemp = 0; wait_n(25);
    phase = "R1"; request(2'd1); wait_n(2); bat_off = 1; overtemp = 1; wait_n(4);
    overtemp = 0; bat_off = 0; bat_on = 0; wait_n(3);
    phase = "R2"; long_rst_sel = 0; bat_on = 1; wait_n(10);
    phase = "R1"; bat_off = 1; @(negedge clk); #1;
    chk("mode after bat_off", mode, 0); chk("reg_en after bat_off", reg_en, 0);
    bat_off = 0; wait_n(10);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule